// File: doc/BRIEF.md
# Read-Cycle Address Command Decoder

This block lets a host send bytes to a cartridge that sits in a read-only option-ROM socket on a CPU with a multiplexed address/data bus. The host has only read cycles, so it carries each payload byte in the low byte of the read address. The block samples the low bus byte on every falling edge of the address-latch strobe, while the bus still holds address. It keeps the sample only when the socket chip select is active.

After reset the block acts as a plain ROM. It answers every selected read and watches the sampled bytes for a fixed six-byte unlock key. Once the whole key has arrived on consecutive selected reads, the block enters a command state. In that state each later selected read hands its low address byte to the command logic behind it, as a byte with a valid strobe. An exit input or the reset brings the block back to ROM behaviour.

All state is clocked on the falling edge of the address-latch strobe. The reset and exit inputs are sampled on that same edge.

Top module: `rd_addr_cmd_decoder`

## Requirements
- R1: When `rst_n` is low at a falling edge of `ale`, the block afterwards shows `cmd_mode` = 0 and `cmd_valid` = 0, and key progress restarts from the first key byte.
- R2: `rom_oe_n` is low exactly while `cs_n` is low, in both ROM and command state.
- R3: While the block is in ROM state, a falling edge never raises `cmd_valid`.
- R4: Six selected reads in a row whose low address bytes equal the key, in order 0x5A, 0xC3, 0x17, 0xE8, 0x3C, 0x96 (parameter `UNLOCK_KEY`, byte 0 in bits 7:0), set `cmd_mode` to 1 after the sixth edge.
- R5: A selected byte that does not match the next expected key byte sets key progress back to 1 if it equals the first key byte, and to 0 otherwise.
- R6: A falling edge with `cs_n` high leaves key progress and `cmd_mode` unchanged, and is followed by `cmd_valid` = 0.
- R7: In command state, a selected read presents its low address byte on `cmd_byte` with `cmd_valid` high for the single `ale` period after that edge.
- R8: `exit_cmd` high at an edge returns the block to ROM state with `cmd_valid` = 0 and key progress 0. A selected byte on that same edge is dropped.
- R9: The byte that completes the key is not delivered as command data. While in command state, bytes equal to key bytes are delivered like any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ale | input | 1 | Address-latch strobe; falling edge samples the bus and clocks all state |
| rst_n | input | 1 | Active-low synchronous reset, sampled on the falling edge of `ale` |
| cs_n | input | 1 | Active-low option-ROM socket select, qualifies the sampled byte |
| ad_lo | input | 8 | Low byte of the multiplexed address/data bus |
| exit_cmd | input | 1 | Returns the block to ROM state at the next falling edge |
| rom_oe_n | output | 1 | Active-low ROM data output enable |
| cmd_mode | output | 1 | 1 while in command state |
| cmd_byte | output | 8 | Last delivered command byte |
| cmd_valid | output | 1 | High for one `ale` period after a delivered byte |

## Verification
Two functions can land on the same falling edge. In command state, the exit request can coincide with a selected read carrying a byte. In ROM state, the completion of the key can coincide with the question of whether that byte counts as command data. The bench drives both collisions on purpose: an exit with `cs_n` low and a fresh byte, and the sixth key byte followed straight away by data. A behavioural model that tracks key progress as an integer decides each outcome. The model expects the exit to win and the byte to vanish. It also expects the completing key byte never to strobe `cmd_valid`.

// File: rtl/rd_addr_cmd_pkg.sv
// Shared types for the read-cycle address command decoder.
package rd_addr_cmd_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        MODE_ROM = 1'b0,
        MODE_CMD = 1'b1
    } dec_mode_e;
endpackage

// File: rtl/rd_addr_qualifier.sv
// Qualifies the low bus byte with the socket select and drives the ROM
// output enable. Assumes cs_n is stable across the falling edge of ale.
module rd_addr_qualifier
    import rd_addr_cmd_pkg::*;
(
    input  logic              cs_n,
    input  logic [BYTE_W-1:0] ad_lo,
    output logic              sel,
    output logic [BYTE_W-1:0] sel_byte,
    output logic              rom_oe_n
);
    // Combinational qualification of the sampled address byte.
    always_comb begin
        sel      = ~cs_n;
        sel_byte = ad_lo;
        rom_oe_n = cs_n;
    end
endmodule

// File: rtl/rd_key_tracker.sv
// Follows progress through the unlock key on qualified bytes in ROM state.
// A mismatch restarts at 1 if the byte equals key byte 0, otherwise at 0.
// Assumes KEY_LEN >= 2. Clocked on the falling edge of ale.
module rd_key_tracker
    import rd_addr_cmd_pkg::*;
#(
    parameter int unsigned          KEY_LEN = 6,
    parameter logic [KEY_LEN*8-1:0] KEY     = 48'h963CE817C35A
) (
    input  logic              ale,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    input  logic              sel,
    input  logic [BYTE_W-1:0] sel_byte,
    output logic              key_done
);
    localparam int unsigned PW = $clog2(KEY_LEN);
    localparam logic [PW-1:0] LAST = PW'(KEY_LEN - 1);

    logic [BYTE_W-1:0] key_bytes [KEY_LEN];
    logic [PW-1:0]     prog_q;
    logic              hit;

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign key_bytes[g] = KEY[g*8 +: 8];
    end

    // Match test of the current byte against the expected key byte.
    always_comb begin
        hit      = active && sel && (sel_byte == key_bytes[prog_q]);
        key_done = hit && (prog_q == LAST);
    end

    // Progress register: advance, restart, or hold.
    always_ff @(negedge ale) begin
        if (!rst_n || clear) begin
            prog_q <= '0;
        end else if (active && sel) begin
            if (key_done)
                prog_q <= '0;
            else if (hit)
                prog_q <= prog_q + 1'b1;
            else if (sel_byte == key_bytes[0])
                prog_q <= PW'(1);
            else
                prog_q <= '0;
        end
    end
endmodule

// File: rtl/rd_cmd_emitter.sv
// Presents delivered command bytes with a one-period valid strobe.
// Clocked on the falling edge of ale; clear wins over load.
module rd_cmd_emitter
    import rd_addr_cmd_pkg::*;
(
    input  logic              ale,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_valid
);
    // Byte holding register and strobe.
    always_ff @(negedge ale) begin
        if (!rst_n || clear) begin
            cmd_byte  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= load;
            if (load)
                cmd_byte <= load_byte;
        end
    end
endmodule

// File: rtl/rd_addr_cmd_decoder.sv
// Top of the read-cycle address command decoder. Starts in ROM state,
// enters command state after the unlock key, and leaves it on exit_cmd or
// reset. All state changes occur on the falling edge of ale.
module rd_addr_cmd_decoder
    import rd_addr_cmd_pkg::*;
#(
    parameter int unsigned          KEY_LEN    = 6,
    parameter logic [KEY_LEN*8-1:0] UNLOCK_KEY = 48'h963CE817C35A
) (
    input  logic       ale,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [7:0] ad_lo,
    input  logic       exit_cmd,
    output logic       rom_oe_n,
    output logic       cmd_mode,
    output logic [7:0] cmd_byte,
    output logic       cmd_valid
);
    dec_mode_e         mode_q;
    logic              sel;
    logic [BYTE_W-1:0] sel_byte;
    logic              key_done;
    logic              in_rom;
    logic              deliver;

    rd_addr_qualifier u_qual (
        .cs_n     (cs_n),
        .ad_lo    (ad_lo),
        .sel      (sel),
        .sel_byte (sel_byte),
        .rom_oe_n (rom_oe_n)
    );

    rd_key_tracker #(.KEY_LEN(KEY_LEN), .KEY(UNLOCK_KEY)) u_key (
        .ale      (ale),
        .rst_n    (rst_n),
        .clear    (exit_cmd),
        .active   (in_rom),
        .sel      (sel),
        .sel_byte (sel_byte),
        .key_done (key_done)
    );

    rd_cmd_emitter u_emit (
        .ale       (ale),
        .rst_n     (rst_n),
        .clear     (exit_cmd),
        .load      (deliver),
        .load_byte (sel_byte),
        .cmd_byte  (cmd_byte),
        .cmd_valid (cmd_valid)
    );

    // State-dependent gating of key tracking and byte delivery.
    always_comb begin
        in_rom   = (mode_q == MODE_ROM) && !exit_cmd;
        deliver  = (mode_q == MODE_CMD) && sel && !exit_cmd;
        cmd_mode = (mode_q == MODE_CMD);
    end

    // Mode register: reset and exit to ROM, key completion to command.
    always_ff @(negedge ale) begin
        if (!rst_n || exit_cmd)
            mode_q <= MODE_ROM;
        else if (key_done)
            mode_q <= MODE_CMD;
    end
endmodule

// File: rtl/rd_addr_cmd_checker.sv
// Port-level properties of the decoder, bound to every instance of the top.
module rd_addr_cmd_checker (
    input logic       ale,
    input logic       rst_n,
    input logic       cs_n,
    input logic [7:0] ad_lo,
    input logic       exit_cmd,
    input logic       rom_oe_n,
    input logic       cmd_mode,
    input logic [7:0] cmd_byte,
    input logic       cmd_valid
);
    assert_reset_clears_R1: assert property (@(negedge ale)
        !rst_n |=> (!cmd_mode && !cmd_valid));

    assert_oe_tracks_select_R2: assert property (@(negedge ale) disable iff (!rst_n)
        rom_oe_n == cs_n);

    assert_no_strobe_in_rom_R3: assert property (@(negedge ale) disable iff (!rst_n)
        !cmd_mode |=> !cmd_valid);

    assert_unselected_edge_R6: assert property (@(negedge ale) disable iff (!rst_n)
        (cs_n && !exit_cmd) |=> (!cmd_valid && cmd_mode == $past(cmd_mode)));

    assert_byte_delivered_R7: assert property (@(negedge ale) disable iff (!rst_n)
        (cmd_mode && !cs_n && !exit_cmd) |=> (cmd_valid && cmd_byte == $past(ad_lo)));

    assert_exit_wins_R8: assert property (@(negedge ale) disable iff (!rst_n)
        exit_cmd |=> (!cmd_mode && !cmd_valid));
endmodule

bind rd_addr_cmd_decoder rd_addr_cmd_checker u_chk (
    .ale       (ale),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ad_lo     (ad_lo),
    .exit_cmd  (exit_cmd),
    .rom_oe_n  (rom_oe_n),
    .cmd_mode  (cmd_mode),
    .cmd_byte  (cmd_byte),
    .cmd_valid (cmd_valid)
);

// File: tb/rd_addr_cmd_decoder_tb.sv
module rd_addr_cmd_decoder_tb_top;
    logic       ale = 1'b1;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] ad_lo = 8'h00;
    logic       exit_cmd = 1'b0;
    logic       rom_oe_n;
    logic       cmd_mode;
    logic [7:0] cmd_byte;
    logic       cmd_valid;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    byte unsigned key [6] = '{8'h5A, 8'hC3, 8'h17, 8'hE8, 8'h3C, 8'h96};
    int  prog = 0;
    bit  m_mode = 0;
    bit  m_valid = 0;
    byte unsigned m_byte = 0;

    always #4 ale = ~ale;

    rd_addr_cmd_decoder dut_i (
        .ale(ale), .rst_n(rst_n), .cs_n(cs_n), .ad_lo(ad_lo),
        .exit_cmd(exit_cmd), .rom_oe_n(rom_oe_n), .cmd_mode(cmd_mode),
        .cmd_byte(cmd_byte), .cmd_valid(cmd_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One ale period: drive after the rising edge, compare after the falling edge.
    task automatic step(input bit rst, input bit sel, input byte unsigned b,
                        input bit ex, input string req);
        @(posedge ale);
        #1;
        rst_n = rst; cs_n = !sel; ad_lo = b; exit_cmd = ex;
        #1;
        chk("R2", rom_oe_n, !sel);
        if (!rst || ex) begin
            m_mode = 0; prog = 0; m_valid = 0;
        end else if (sel) begin
            m_valid = m_mode;
            if (m_mode) m_byte = b;
            else if (b == key[prog]) begin
                prog++;
                if (prog == 6) begin m_mode = 1; prog = 0; end
            end else prog = (b == key[0]) ? 1 : 0;
        end else m_valid = 0;
        @(negedge ale);
        #2;
        chk(req, cmd_mode, m_mode);
        chk(req, cmd_valid, m_valid);
        if (m_valid) chk(req, cmd_byte, m_byte);
    endtask

    task automatic send_key(input string req);
        for (int i = 0; i < 6; i++) step(1, 1, key[i], 0, req);
    endtask

    initial begin
        // R1: reset state
        step(0, 0, 8'h00, 0, "R1");
        step(0, 1, 8'h5A, 0, "R1");
        // R3: ordinary ROM reads give no strobe
        step(1, 1, 8'h10, 0, "R3");
        step(1, 1, 8'hFF, 0, "R3");
        // R6: unselected edges between key bytes do not disturb progress
        for (int i = 0; i < 6; i++) begin
            step(1, 1, key[i], 0, "R4");
            step(1, 0, 8'h77, 0, "R6");
        end
        step(1, 1, 8'hA1, 0, "R7");
        step(1, 0, 8'h5A, 0, "R6");
        step(1, 1, 8'h00, 1, "R8");
        // R5: mismatch equal to key byte 0 restarts at progress 1
        step(1, 1, 8'h5A, 0, "R5");
        step(1, 1, 8'hC3, 0, "R5");
        step(1, 1, 8'h17, 0, "R5");
        step(1, 1, 8'h5A, 0, "R5");
        for (int i = 1; i < 6; i++) step(1, 1, key[i], 0, "R5");
        // R9: key completion byte never delivered; next byte is
        step(1, 1, 8'h5A, 0, "R9");
        step(1, 1, 8'h96, 0, "R9");
        step(1, 1, 8'h3C, 0, "R7");
        step(1, 0, 8'h3C, 1, "R8");
        // R5: mismatch not equal to key byte 0 restarts at 0
        step(1, 1, 8'h5A, 0, "R5");
        step(1, 1, 8'hC3, 0, "R5");
        step(1, 1, 8'h44, 0, "R5");
        for (int i = 1; i < 6; i++) step(1, 1, key[i], 0, "R5");
        send_key("R4");
        // R8: exit and selected byte on the same edge
        step(1, 1, 8'h21, 0, "R7");
        step(1, 1, 8'hEE, 1, "R8");
        step(1, 1, 8'h96, 0, "R3");
        // R1: reset from command state
        send_key("R4");
        step(1, 1, 8'h55, 0, "R7");
        step(0, 1, 8'h66, 0, "R1");
        step(1, 1, 8'h66, 0, "R1");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule